// File: doc/BRIEF.md
# Wrapping Snake Game State Engine

This block keeps the complete state of a snake game played on a 40 by 30 cell field and advances it by one move on each frame tick. The state has four parts: the head cell, a chain of up to MAX_TAILS body segments, a segment count and an apple cell. It also carries two sticky flags, one for a lost game and one for a full-length snake. The field wraps at every edge, so a snake that leaves one border comes back at the opposite border.

The block also works as a pixel lookup. A video pipeline presents pixel coordinates from a 640x480 raster, and the block returns at once which entity occupies the 16x16 cell under that pixel. It compares the cell against every segment in parallel, so the answer does not depend on the snake's length. The tick is meant to come in the blanking interval after each frame, so that the state never changes while the picture is being drawn.

Top module: `snake_state_engine`

## Requirements
- R1: After reset the head is at cell (20,15) and the apple at cell (5,5). The score is 0, and the `won` and `over` flags are 0.
- R2: On each clock with `frame_tick` high and `over` low, the head moves one cell in the direction given by `dir`. The codes are 0 = up (y-1), 1 = right (x+1), 2 = down (y+1) and 3 = left (x-1). Without a tick the state does not change.
- R3: Movement wraps around the field. Left from x=0 gives x=39, right from x=39 gives x=0, up from y=0 gives y=29 and down from y=29 gives y=0.
- R4: The snake eats when the new head cell equals the apple cell and the count is below MAX_TAILS. The count then rises by one, and the occupied body cells become the old body plus the previous head cell. The apple moves to (X mod 40, Y mod 30), where X and Y are the two random registers as they stood just before that clock edge.
- R5: The two random registers are 6-bit shift registers with feedback polynomial x^6+x^5+1. Each step shifts left, and the new bit 0 is bit 5 XOR bit 4. The X register is seeded with 6'h01 and the Y register with 6'h2D while reset is high, and both step on every clock after reset.
- R6: On a move without eating, segment n+1 takes the old cell of segment n and segment 0 takes the old head cell. The count is unchanged.
- R7: When the count reaches MAX_TAILS, `won` goes to 1 and stays there. From then on, moving onto the apple adds no segment, and play continues.
- R8: When the new head cell equals the cell of any segment that is active after the move, `over` goes to 1. Every later tick then leaves the head, the body, the score and the flags unchanged.
- R9: `ent` reports the cell (pix_x/16, pix_y/16) with the codes 0 = nothing, 1 = head, 2 = tail and 3 = apple. Head wins over tail and tail wins over apple. A pixel outside the 640x480 area returns 0.
- R10: `score` always equals the number of active segments and never exceeds MAX_TAILS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe that advances the game by one move |
| dir | input | 2 | Move direction code |
| pix_x | input | 10 | Pixel column to query |
| pix_y | input | 9 | Pixel row to query |
| ent | output | 2 | Entity code for the queried cell |
| score | output | $clog2(MAX_TAILS+1) (8 by default) | Number of active segments |
| won | output | 1 | Snake has reached its maximum length |
| over | output | 1 | Head has run into the body; play is frozen |

## Verification
The bench drives the head across all four borders and checks the landing cells. A design that clamps at an edge, or wraps to cell 40 or 31, puts the head in the wrong cell. It steers the snake onto a series of apples until the length cap is reached, predicting each new apple from its own model of the random registers. An off-by-one in apple timing or in the modulo therefore shows up at once as a missing apple code. After the cap, it moves the head onto the apple to catch a design that grows past the limit, then closes a square loop to force a head-to-body hit. Two ticks after the hit catch a design that keeps moving once `over` is set. Pixel queries at the cell edges, at the priority overlaps and outside the raster catch a wrong pixel-to-cell mapping and inverted priority.

// File: rtl/snake_pkg.sv
package snake_pkg;

    localparam int GRID_W        = 40;
    localparam int GRID_H        = 30;
    localparam int CELL_LOG2     = 4;
    localparam int MAX_TAILS_DEF = 128;
    localparam int XW            = $clog2(GRID_W);
    localparam int YW            = $clog2(GRID_H);
    localparam int PXW           = XW + CELL_LOG2;
    localparam int PYW           = YW + CELL_LOG2;
    localparam int RW            = 6;

    localparam logic [XW-1:0] X_LAST = XW'(GRID_W - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(GRID_H - 1);

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } cell_t;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_RIGHT = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_LEFT  = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ENT_NONE  = 2'd0,
        ENT_HEAD  = 2'd1,
        ENT_TAIL  = 2'd2,
        ENT_APPLE = 2'd3
    } ent_e;

    localparam cell_t HEAD_HOME  = '{x: XW'(20), y: YW'(15)};
    localparam cell_t APPLE_HOME = '{x: XW'(5),  y: YW'(5)};

    function automatic cell_t step_cell(cell_t c, dir_e d);
        cell_t r;
        r = c;
        case (d)
            DIR_UP:    r.y = (c.y == '0)     ? Y_LAST : c.y - 1'b1;
            DIR_DOWN:  r.y = (c.y == Y_LAST) ? '0     : c.y + 1'b1;
            DIR_LEFT:  r.x = (c.x == '0)     ? X_LAST : c.x - 1'b1;
            default:   r.x = (c.x == X_LAST) ? '0     : c.x + 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [RW-1:0] rng_next(logic [RW-1:0] q);
        return {q[RW-2:0], q[RW-1] ^ q[RW-2]};
    endfunction

    function automatic cell_t rand_cell(logic [RW-1:0] rx, logic [RW-1:0] ry);
        cell_t r;
        r.x = XW'(rx % RW'(GRID_W));
        r.y = YW'(ry % RW'(GRID_H));
        return r;
    endfunction

    function automatic cell_t pixel_cell(logic [PXW-1:0] px, logic [PYW-1:0] py);
        cell_t r;
        r.x = px[PXW-1:CELL_LOG2];
        r.y = py[PYW-1:CELL_LOG2];
        return r;
    endfunction

endpackage

// File: rtl/snake_rng.sv
module snake_rng
    import snake_pkg::*;
#(
    parameter logic [RW-1:0] SEED = 6'h01
) (
    input  logic          clk,
    input  logic          rst,
    output logic [RW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEED;
        end else begin
            q <= rng_next(q);
        end
    end

endmodule

// File: rtl/snake_body.sv
module snake_body
    import snake_pkg::*;
#(
    parameter int N = MAX_TAILS_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  cell_t           entry,
    output cell_t [N-1:0]   segs
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_seg
            always_ff @(posedge clk) begin
                if (rst) begin
                    segs[i] <= '0;
                end else if (shift_en) begin
                    if (i == 0) begin
                        segs[i] <= entry;
                    end else begin
                        segs[i] <= segs[(i == 0) ? 0 : i-1];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/snake_tail_hit.sv
module snake_tail_hit
    import snake_pkg::*;
#(
    parameter int N  = MAX_TAILS_DEF,
    parameter int CW = $clog2(N + 1)
) (
    input  cell_t           probe,
    input  cell_t [N-1:0]   segs,
    input  logic [CW-1:0]   limit,
    output logic            hit
);

    logic [N-1:0] match;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_cmp
            assign match[i] = (segs[i] == probe) && (CW'(i) < limit);
        end
    endgenerate

    assign hit = |match;

endmodule

// File: rtl/snake_state_engine.sv
module snake_state_engine
    import snake_pkg::*;
#(
    parameter int MAX_TAILS = MAX_TAILS_DEF,
    localparam int CW = $clog2(MAX_TAILS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic [1:0]       dir,
    input  logic [PXW-1:0]   pix_x,
    input  logic [PYW-1:0]   pix_y,
    output logic [1:0]       ent,
    output logic [CW-1:0]    score,
    output logic             won,
    output logic             over
);

    localparam logic [CW-1:0] CAP = CW'(MAX_TAILS);

    cell_t                 head_q;
    cell_t                 apple_q;
    logic [CW-1:0]         count_q;
    logic                  won_q;
    logic                  over_q;

    cell_t                 head_nxt;
    cell_t                 query_cell;
    cell_t [MAX_TAILS-1:0] segs;
    logic [RW-1:0]         rng_x;
    logic [RW-1:0]         rng_y;
    logic                  advance;
    logic                  full;
    logic                  eat;
    logic [CW-1:0]         coll_limit;
    logic                  coll_hit;
    logic                  query_tail;
    ent_e                  ent_sel;

    snake_rng #(.SEED(6'h01)) u_rng_x (.clk(clk), .rst(rst), .q(rng_x));
    snake_rng #(.SEED(6'h2D)) u_rng_y (.clk(clk), .rst(rst), .q(rng_y));

    assign advance  = frame_tick && !over_q;
    assign head_nxt = step_cell(head_q, dir_e'(dir));
    assign full     = (count_q == CAP);
    assign eat      = (head_nxt == apple_q) && !full;

    // After the move the chain holds the old head plus the old segments,
    // minus the last one unless the snake grows.
    always_comb begin
        if (eat) begin
            coll_limit = count_q;
        end else if (count_q == '0) begin
            coll_limit = '0;
        end else begin
            coll_limit = count_q - 1'b1;
        end
    end

    snake_body #(.N(MAX_TAILS)) u_body (
        .clk      (clk),
        .rst      (rst),
        .shift_en (advance),
        .entry    (head_q),
        .segs     (segs)
    );

    snake_tail_hit #(.N(MAX_TAILS), .CW(CW)) u_coll (
        .probe (head_nxt),
        .segs  (segs),
        .limit (coll_limit),
        .hit   (coll_hit)
    );

    assign query_cell = pixel_cell(pix_x, pix_y);

    snake_tail_hit #(.N(MAX_TAILS), .CW(CW)) u_query (
        .probe (query_cell),
        .segs  (segs),
        .limit (count_q),
        .hit   (query_tail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= HEAD_HOME;
            apple_q <= APPLE_HOME;
            count_q <= '0;
            won_q   <= 1'b0;
            over_q  <= 1'b0;
        end else if (advance) begin
            head_q <= head_nxt;
            over_q <= coll_hit;
            if (eat) begin
                count_q <= count_q + 1'b1;
                apple_q <= rand_cell(rng_x, rng_y);
                if (count_q + 1'b1 == CAP) begin
                    won_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (query_cell == head_q) begin
            ent_sel = ENT_HEAD;
        end else if (query_tail) begin
            ent_sel = ENT_TAIL;
        end else if (query_cell == apple_q) begin
            ent_sel = ENT_APPLE;
        end else begin
            ent_sel = ENT_NONE;
        end
    end

    assign ent   = ent_sel;
    assign score = count_q;
    assign won   = won_q;
    assign over  = over_q;

endmodule

// File: rtl/snake_state_chk.sv
module snake_state_chk #(
    parameter int MAX_TAILS = 128,
    parameter int CW = $clog2(MAX_TAILS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_tick,
    input logic [CW-1:0] score,
    input logic          won,
    input logic          over
);

    // R8
    over_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        over |=> over);

    // R8
    frozen_state_chk: assert property (@(posedge clk) disable iff (rst)
        over |=> ($stable(score) && $stable(won)));

    // R2
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> ($stable(score) && $stable(won) && $stable(over)));

    // R10
    score_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (score == $past(score) || score == $past(score) + 1'b1));

    // R7
    won_at_cap_chk: assert property (@(posedge clk) disable iff (rst)
        won == (score == CW'(MAX_TAILS)));

    // R10
    score_cap_chk: assert property (@(posedge clk) disable iff (rst)
        score <= CW'(MAX_TAILS));

endmodule

bind snake_state_engine snake_state_chk #(.MAX_TAILS(MAX_TAILS), .CW(CW)) u_state_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .score      (score),
    .won        (won),
    .over       (over)
);

// File: tb/snake_state_engine_bench.sv
module snake_state_engine_bench;

    localparam int BT = 6;
    localparam int CWB = $clog2(BT + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_tick = 1'b0;
    logic [1:0]     dir = 2'd0;
    logic [9:0]     pix_x = '0;
    logic [8:0]     pix_y = '0;
    logic [1:0]     ent;
    logic [CWB-1:0] score;
    logic           won;
    logic           over;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    snake_state_engine #(.MAX_TAILS(BT)) u_snake_state_engine (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .dir(dir),
        .pix_x(pix_x), .pix_y(pix_y), .ent(ent), .score(score),
        .won(won), .over(over)
    );

    // Reference random registers, built from R5
    logic [5:0] mrx, mry;
    always @(posedge clk) begin
        if (rst) begin
            mrx <= 6'h01;
            mry <= 6'h2D;
        end else begin
            mrx <= {mrx[4:0], mrx[5] ^ mrx[4]};
            mry <= {mry[4:0], mry[5] ^ mry[4]};
        end
    end

    // Reference game state
    int hx, hy, ax, ay, cnt, mwon, mover, last;
    int tx [0:7];
    int ty [0:7];
    bit done_flag;

    // Vectors: {dir, repeats, expected x, expected y} (R2, R3)
    localparam logic [18:0] VEC [0:7] = '{
        {2'd3, 6'd20, 6'd0,  5'd15},
        {2'd3, 6'd1,  6'd39, 5'd15},
        {2'd1, 6'd1,  6'd0,  5'd15},
        {2'd0, 6'd15, 6'd0,  5'd0},
        {2'd0, 6'd1,  6'd0,  5'd29},
        {2'd2, 6'd1,  6'd0,  5'd0},
        {2'd3, 6'd1,  6'd39, 5'd0},
        {2'd1, 6'd1,  6'd0,  5'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic query(input int cx, input int cy, output int e);
        pix_x = 10'(cx * 16 + 7);
        pix_y = 9'(cy * 16 + 7);
        #1;
        e = int'(ent);
    endtask

    task automatic move(input int x, input int y, input int d, output int nx, output int ny);
        nx = x; ny = y;
        case (d)
            0: ny = (y == 0) ? 29 : y - 1;
            2: ny = (y == 29) ? 0 : y + 1;
            3: nx = (x == 0) ? 39 : x - 1;
            default: nx = (x == 39) ? 0 : x + 1;
        endcase
    endtask

    task automatic model_reset();
        hx = 20; hy = 15; ax = 5; ay = 5; cnt = 0; mwon = 0; mover = 0; last = 1;
        for (int i = 0; i < 8; i++) begin tx[i] = 0; ty[i] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; frame_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic bit in_tails(int x, int y, int lim);
        for (int i = 0; i < lim; i++)
            if (tx[i] == x && ty[i] == y) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input int d);
        int nx, ny, lim, rx, ry;
        bit eat;
        @(negedge clk);
        dir = 2'(d);
        frame_tick = 1'b1;
        rx = int'(mrx); ry = int'(mry);
        @(negedge clk);
        frame_tick = 1'b0;
        last = d;
        if (!mover) begin
            move(hx, hy, d, nx, ny);
            eat = (nx == ax && ny == ay && cnt < BT);
            lim = eat ? cnt : ((cnt == 0) ? 0 : cnt - 1);
            mover = in_tails(nx, ny, lim);
            for (int i = BT - 1; i > 0; i--) begin tx[i] = tx[i-1]; ty[i] = ty[i-1]; end
            tx[0] = hx; ty[0] = hy;
            hx = nx; hy = ny;
            if (eat) begin
                cnt++;
                ax = rx % 40; ay = ry % 30;
                if (cnt == BT) mwon = 1;
            end
        end
    endtask

    task automatic check_state(input string req);
        int e;
        query(hx, hy, e);
        chk(e == 1, {req, " head cell"}, e, 1);
        chk(int'(score) == cnt, "R10 score", int'(score), cnt);
        chk(int'(won) == mwon, "R7 won flag", int'(won), mwon);
        chk(int'(over) == mover, "R8 over flag", int'(over), mover);
        if (!(ax == hx && ay == hy) && !in_tails(ax, ay, cnt)) begin
            query(ax, ay, e);
            chk(e == 3, "R4 apple cell", e, 3);
        end
        if (cnt > 0 && !(tx[0] == hx && ty[0] == hy)) begin
            query(tx[0], ty[0], e);
            chk(e == 2, "R6 first segment", e, 2);
        end
    endtask

    function automatic bit occupied_next(int d);
        int nx, ny;
        nx = hx; ny = hy;
        case (d)
            0: ny = (hy == 0) ? 29 : hy - 1;
            2: ny = (hy == 29) ? 0 : hy + 1;
            3: nx = (hx == 0) ? 39 : hx - 1;
            default: nx = (hx == 39) ? 0 : hx + 1;
        endcase
        return in_tails(nx, ny, (cnt == 0) ? 0 : cnt - 1);
    endfunction

    function automatic int steer();
        int pref [0:5];
        pref[0] = (ax > hx) ? 1 : 3;
        pref[1] = (ay > hy) ? 2 : 0;
        pref[2] = 0; pref[3] = 1; pref[4] = 2; pref[5] = 3;
        if (ax == hx) pref[0] = pref[1];
        if (ay == hy) pref[1] = pref[0];
        for (int i = 0; i < 6; i++) begin
            if (!(cnt > 0 && pref[i] == (last ^ 2)) && !occupied_next(pref[i]))
                return pref[i];
        end
        return last;
    endfunction

    initial begin
        int e, tries;
        done_flag = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        query(20, 15, e);
        chk(e == 1, "R1 head home", e, 1);
        query(5, 5, e);
        chk(e == 3, "R1 apple home", e, 3);
        query(0, 0, e);
        chk(e == 0, "R1 empty cell", e, 0);
        chk(score == 0, "R1 score", int'(score), 0);
        chk(won == 0 && over == 0, "R1 flags", int'({won, over}), 0);

        // R2 no tick, no move
        repeat (5) @(negedge clk);
        query(20, 15, e);
        chk(e == 1, "R2 idle head", e, 1);

        // R2 R3 vector walk
        for (int v = 0; v < 8; v++) begin
            for (int r = 0; r < int'(VEC[v][16:11]); r++) step(int'(VEC[v][18:17]));
            chk(hx == int'(VEC[v][10:5]) && hy == int'(VEC[v][4:0]), "R3 model landing",
                hx * 100 + hy, int'(VEC[v][10:5]) * 100 + int'(VEC[v][4:0]));
            query(int'(VEC[v][10:5]), int'(VEC[v][4:0]), e);
            chk(e == 1, "R3 wrap landing", e, 1);
        end

        // R9 pixel mapping and out-of-range
        pix_x = 10'(0 * 16 + 15); pix_y = 9'(0 * 16 + 15); #1;
        chk(ent == 2'd1, "R9 cell corner", int'(ent), 1);
        pix_x = 10'(16); pix_y = 9'(0); #1;
        chk(ent == 2'd0, "R9 next cell", int'(ent), 0);
        pix_x = 10'd640; pix_y = 9'd8; #1;
        chk(ent == 2'd0, "R9 outside x", int'(ent), 0);
        pix_x = 10'd8; pix_y = 9'd480; #1;
        chk(ent == 2'd0, "R9 outside y", int'(ent), 0);

        // R4 R5 R6 R7 growth up to the cap
        tries = 0;
        while (!mwon && tries < 4000) begin
            step(steer());
            check_state("R4 growth");
            if (mover) do_reset();
            tries++;
        end
        chk(won == 1, "R7 cap reached", int'(won), 1);
        chk(score == BT, "R7 cap score", int'(score), BT);

        // R7 walk onto the apple after the cap
        tries = 0;
        while (!(hx == ax && hy == ay) && tries < 200 && !mover) begin
            step(steer());
            tries++;
        end
        check_state("R7 apple after cap");
        chk(score == BT, "R7 no growth past cap", int'(score), BT);
        chk(over == 0, "R7 play continues", int'(over), 0);

        // R8 close a square loop into the body
        if (!mover) begin
            for (int k = 0; k < 4; k++) step((last + 1) % 4);
        end
        check_state("R8 collision");
        chk(over == 1, "R8 collision flag", int'(over), 1);

        // R8 frozen
        step(1);
        step(2);
        check_state("R8 frozen");

        // R9 priority: head over tail after the hit
        query(hx, hy, e);
        chk(e == 1, "R9 head priority", e, 1);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule